// File: doc/BRIEF.md
# Serial Audio Stereo Receiver with Format Detection

This block takes stereo PCM from a three-wire serial audio link made of a bit clock, a word clock and a data line, and delivers one left and one right sample per frame. All three link wires are oversampled by the core clock. A rising edge of the bit clock is found in the synchronized copy, and data and word clock are taken at that edge. A static format input picks the bit alignment and the channel polarity. The block also measures the word-clock pulse widths and chooses among right-justified 16-bit, I2S (16 to 24 bits), packed 16-bit and short-sync DSP framing.

Each word is returned 24 bits wide with its MSB at bit 23. A one-cycle strobe marks a complete frame. A one-cycle error strobe replaces the sample when a frame's word-clock halves are too short. The detected framing appears as a small mode code. The mode is classified from the widths measured in the preceding word-clock periods, so the first frame after reset never produces a sample.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is asserted and after its release, before any frame completes, left_o, right_o, valid_o and err_o are zero and mode_o is 0 (none).
- R2: With fmt_i high and I2S framing (mode_o = 2), word clock low carries the left word and high carries the right word. The MSB is the bit sampled on the second bit-clock rising edge after a word-clock change.
- R3: In I2S framing a word shorter than 24 bits comes out with zeros below its LSB. A word longer than 24 bits keeps only its first 24 bits.
- R4: With fmt_i low (mode_o = 1), word clock high carries the left word. The word is the 16 bits sampled on the last 16 rising edges before a word-clock change, placed in bits 23:8 with bits 7:0 zero.
- R5: When the previous high half and low half each lasted exactly 16 bit clocks, mode_o is 3 (packed) and each word carries 16 bits in bits 23:8, for either level of fmt_i.
- R6: A word-clock high pulse of 4 bit clocks or fewer selects DSP framing: mode_o is 4 when fmt_i is low and 5 when fmt_i is high. A pulse of 5 bit clocks does not select it. A DSP frame is 32 bits, the left 16 bits followed by the right 16 bits, each placed in bits 23:8.
- R7: In DSP framing with fmt_i high, the MSB is the bit sampled on the edge that first sees the word clock high. With fmt_i low, the MSB is the bit sampled on the edge that first sees it low again.
- R8: valid_o pulses for exactly one core clock per completed frame. left_o and right_o change only in that cycle.
- R9: Outside DSP framing, a frame with a word-clock half shorter than 16 bit clocks pulses err_o for one cycle and produces no valid_o pulse. valid_o and err_o are never high together.
- R10: The mode is refreshed at each rising word-clock change from the preceding high-half and low-half widths. mode_o never returns to 0 once set, and the first frame after reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, oversamples the link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock / frame sync |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 1 | Static format select (alignment, polarity, DSP variant) |
| left_o | output | 24 | Left sample, MSB aligned |
| right_o | output | 24 | Right sample, MSB aligned |
| valid_o | output | 1 | One-cycle strobe per completed frame |
| err_o | output | 1 | One-cycle strobe for a frame with a too-short half |
| mode_o | output | 3 | Detected framing: 0 none, 1 right-justified, 2 I2S, 3 packed, 4 DSP late, 5 DSP early |

## Verification
Checks that run on every cycle cover the following: valid and error strobes are one cycle wide and never high together, the sample outputs hold between strobes, the mode does not fall back to none, and DSP samples carry zeros in their low byte. Bit alignment, channel polarity, zero padding and truncation, the width thresholds that select packed and DSP framing, and the dropped first frame can only be shown by scenarios. In those scenarios the bench builds serial streams of known words and compares the recovered samples.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;
  typedef enum logic [2:0] {
    MODE_NONE      = 3'd0,
    MODE_RJ16      = 3'd1,
    MODE_I2S       = 3'd2,
    MODE_PACK16    = 3'd3,
    MODE_DSP_LATE  = 3'd4,
    MODE_DSP_EARLY = 3'd5
  } rx_mode_e;

  function automatic logic mode_is_dsp(rx_mode_e m);
    return (m == MODE_DSP_LATE) || (m == MODE_DSP_EARLY);
  endfunction

  function automatic logic mode_is_std(rx_mode_e m);
    return (m == MODE_RJ16) || (m == MODE_I2S) || (m == MODE_PACK16);
  endfunction
endpackage

// File: rtl/aud_ser_rx_sync.sv
module aud_ser_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic ws_o,
  output logic sd_o
);
  logic [2:0] pipe_q [STAGES];
  logic       bck_last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= '0;
        else         pipe_q[g] <= {bck_i, ws_i, sd_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= '0;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bck_last_q <= 1'b0;
    else         bck_last_q <= pipe_q[STAGES-1][2];

  assign bit_stb_o = pipe_q[STAGES-1][2] & ~bck_last_q;
  assign ws_o      = pipe_q[STAGES-1][1];
  assign sd_o      = pipe_q[STAGES-1][0];
endmodule

// File: rtl/aud_ser_rx_timing.sv
module aud_ser_rx_timing
  import aud_ser_rx_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int STD_W        = 16,
  parameter int DSP_SYNC_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             ws_i,
  input  logic             fmt_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] half_len_o,
  output logic [CNT_W-1:0] hi_len_o,
  output logic [CNT_W-1:0] lo_len_o,
  output rx_mode_e         mode_o
);
  logic             ws_prev_q, seen_q, have_hi_q;
  logic [CNT_W-1:0] hcnt_q, hi_len_q, lo_len_q;
  rx_mode_e         mode_q;

  function automatic rx_mode_e classify(logic [CNT_W-1:0] hi, logic [CNT_W-1:0] lo, logic fmt);
    if (hi <= CNT_W'(DSP_SYNC_MAX))
      return fmt ? MODE_DSP_EARLY : MODE_DSP_LATE;
    else if (hi == CNT_W'(STD_W) && lo == CNT_W'(STD_W))
      return MODE_PACK16;
    else
      return fmt ? MODE_I2S : MODE_RJ16;
  endfunction

  assign rise_o = bit_stb_i &  ws_i & ~ws_prev_q;
  assign fall_o = bit_stb_i & ~ws_i &  ws_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      have_hi_q <= 1'b0;
      hcnt_q    <= '0;
      hi_len_q  <= '0;
      lo_len_q  <= '0;
      mode_q    <= MODE_NONE;
    end else if (bit_stb_i) begin
      ws_prev_q <= ws_i;
      if (rise_o || fall_o) begin
        hcnt_q <= CNT_W'(1);
        seen_q <= 1'b1;
      end else if (hcnt_q != '1) begin
        hcnt_q <= hcnt_q + 1'b1;
      end
      // half widths only count once a full half has been bounded
      if (fall_o && seen_q) begin
        hi_len_q  <= hcnt_q;
        have_hi_q <= 1'b1;
      end
      if (rise_o && seen_q) begin
        lo_len_q <= hcnt_q;
        if (have_hi_q) mode_q <= classify(hi_len_q, hcnt_q, fmt_i);
      end
    end
  end

  assign half_len_o = hcnt_q;
  assign hi_len_o   = hi_len_q;
  assign lo_len_o   = lo_len_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/aud_ser_rx_std.sv
module aud_ser_rx_std
  import aud_ser_rx_pkg::*;
#(
  parameter int OUT_W    = 24,
  parameter int STD_W    = 16,
  parameter int MIN_HALF = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sd_i,
  input  logic             fmt_i,
  input  rx_mode_e         mode_i,
  input  logic [CNT_W-1:0] half_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic [CNT_W-1:0] lo_len_i,
  output logic             vld_o,
  output logic             err_o,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o
);
  localparam int IDX_W = $clog2(OUT_W + 1);
  localparam int PAD_W = OUT_W - STD_W;

  logic [OUT_W-1:0] acc_q, ins, acc_full, i2s_word, rj_word, word, left_q;
  logic [IDX_W-1:0] idx_q;
  logic [STD_W-1:0] sh_q;
  logic             have_left_q, trans, left_evt, end_evt, len_ok, frame_evt;
  logic [CNT_W-1:0] other_len;

  assign trans = rise_i | fall_i;

  // left-justified capture: bits from the 2nd edge of a half through the next change edge
  always_comb begin
    ins = '0;
    if (idx_q < IDX_W'(OUT_W)) ins[IDX_W'(OUT_W - 1) - idx_q] = sd_i;
  end
  assign acc_full = acc_q | ins;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (bit_stb_i) begin
      sh_q <= {sh_q[STD_W-2:0], sd_i};
      if (trans) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= acc_full;
        if (idx_q < IDX_W'(OUT_W)) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign i2s_word = (mode_i == MODE_PACK16) ? {acc_full[OUT_W-1 -: STD_W], {PAD_W{1'b0}}} : acc_full;
  assign rj_word  = {sh_q, {PAD_W{1'b0}}};
  assign word     = fmt_i ? i2s_word : rj_word;

  // polarity: fmt high -> left on low word clock, fmt low -> left on high
  assign left_evt = fmt_i ? rise_i : fall_i;
  assign end_evt  = fmt_i ? fall_i : rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q      <= '0;
      have_left_q <= 1'b0;
    end else if (left_evt) begin
      left_q      <= word;
      have_left_q <= 1'b1;
    end else if (end_evt) begin
      have_left_q <= 1'b0;
    end
  end

  assign other_len = fmt_i ? lo_len_i : hi_len_i;
  assign len_ok    = (half_len_i >= CNT_W'(MIN_HALF)) && (other_len >= CNT_W'(MIN_HALF));
  assign frame_evt = end_evt & have_left_q & mode_is_std(mode_i);
  assign vld_o     = frame_evt &  len_ok;
  assign err_o     = frame_evt & ~len_ok;
  assign left_o    = left_q;
  assign right_o   = word;
endmodule

// File: rtl/aud_ser_rx_dsp.sv
module aud_ser_rx_dsp
  import aud_ser_rx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int STD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sd_i,
  input  logic             fmt_i,
  input  rx_mode_e         mode_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o
);
  localparam int FRAME_BITS = 2 * STD_W;
  localparam int DCNT_W     = $clog2(FRAME_BITS + 1);
  localparam int PAD_W      = OUT_W - STD_W;

  logic [FRAME_BITS-1:0] dsh_q, nx;
  logic [DCNT_W-1:0]     cnt_q;
  logic                  act_q, start, done;

  // early variant starts on the sync rise, late variant on the sync fall
  assign start = fmt_i ? rise_i : fall_i;
  assign nx    = {dsh_q[FRAME_BITS-2:0], sd_i};
  assign done  = bit_stb_i & act_q & ~start & (cnt_q == DCNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsh_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      dsh_q <= nx;
      cnt_q <= DCNT_W'(1);
      act_q <= 1'b1;
    end else if (bit_stb_i && act_q) begin
      dsh_q <= nx;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == DCNT_W'(FRAME_BITS - 1)) act_q <= 1'b0;
    end
  end

  assign vld_o   = done & mode_is_dsp(mode_i);
  assign left_o  = {nx[FRAME_BITS-1 -: STD_W], {PAD_W{1'b0}}};
  assign right_o = {nx[STD_W-1:0], {PAD_W{1'b0}}};
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_ser_rx_pkg::*;
#(
  parameter int OUT_W        = 24,
  parameter int STD_W        = 16,
  parameter int MIN_HALF     = 16,
  parameter int DSP_SYNC_MAX = 4,
  parameter int CNT_W        = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic             fmt_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             err_o,
  output logic [2:0]       mode_o
);
  logic             bit_stb, ws_s, sd_s, rise, fall;
  logic [CNT_W-1:0] half_len, hi_len, lo_len;
  rx_mode_e         mode;
  logic             std_vld, std_err, dsp_vld;
  logic [OUT_W-1:0] std_l, std_r, dsp_l, dsp_r;
  logic [OUT_W-1:0] left_q, right_q;
  logic             valid_q, err_q;

  aud_ser_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bck_i, .ws_i, .sd_i,
    .bit_stb_o(bit_stb), .ws_o(ws_s), .sd_o(sd_s)
  );

  aud_ser_rx_timing #(.CNT_W(CNT_W), .STD_W(STD_W), .DSP_SYNC_MAX(DSP_SYNC_MAX)) u_timing (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .ws_i(ws_s), .fmt_i,
    .rise_o(rise), .fall_o(fall), .half_len_o(half_len),
    .hi_len_o(hi_len), .lo_len_o(lo_len), .mode_o(mode)
  );

  aud_ser_rx_std #(.OUT_W(OUT_W), .STD_W(STD_W), .MIN_HALF(MIN_HALF), .CNT_W(CNT_W)) u_std (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .rise_i(rise), .fall_i(fall), .sd_i(sd_s),
    .fmt_i, .mode_i(mode), .half_len_i(half_len), .hi_len_i(hi_len), .lo_len_i(lo_len),
    .vld_o(std_vld), .err_o(std_err), .left_o(std_l), .right_o(std_r)
  );

  aud_ser_rx_dsp #(.OUT_W(OUT_W), .STD_W(STD_W)) u_dsp (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .rise_i(rise), .fall_i(fall), .sd_i(sd_s),
    .fmt_i, .mode_i(mode), .vld_o(dsp_vld), .left_o(dsp_l), .right_o(dsp_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= std_vld | dsp_vld;
      err_q   <= std_err;
      if (std_vld) begin
        left_q  <= std_l;
        right_q <= std_r;
      end else if (dsp_vld) begin
        left_q  <= dsp_l;
        right_q <= dsp_r;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign mode_o  = mode;
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk
  import aud_ser_rx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int STD_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o,
  input logic             valid_o,
  input logic             err_o,
  input logic [2:0]       mode_o
);
  // R9
  valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R8
  words_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R10
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_NONE) |=> (mode_o != MODE_NONE));

  // R10
  valid_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mode_o != MODE_NONE));

  // R6
  dsp_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (mode_o == MODE_DSP_LATE || mode_o == MODE_DSP_EARLY)) |->
      (left_o[OUT_W-STD_W-1:0] == '0 && right_o[OUT_W-STD_W-1:0] == '0));
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.OUT_W(OUT_W), .STD_W(STD_W)) u_chk (
  .clk_i, .rst_ni, .left_o, .right_o, .valid_o, .err_o, .mode_o
);

// File: tb/sim_aud_ser_rx.sv
module sim_aud_ser_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0, ws = 1'b0, sd = 1'b0, fmt = 1'b0;
  logic [23:0] left, right;
  logic        valid, err;
  logic [2:0]  mode;

  int checks = 0, errors = 0;
  int got_n = 0, err_n = 0, run = 0, max_run = 0;
  logic [23:0] got_l [0:15];
  logic [23:0] got_r [0:15];
  logic [31:0] tx_l [0:7];
  logic [31:0] tx_r [0:7];
  logic        dly = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  aud_ser_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd), .fmt_i(fmt),
    .left_o(left), .right_o(right), .valid_o(valid), .err_o(err), .mode_o(mode)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0;
    end else begin
      if (valid) begin
        if (got_n < 16) begin
          got_l[got_n] = left;
          got_r[got_n] = right;
        end
        got_n++;
        run++;
        if (run > max_run) max_run = run;
      end else begin
        run = 0;
      end
      if (err) err_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic f);
    rst_n = 1'b0;
    bck = 1'b0; ws = 1'b0; sd = 1'b0; dly = 1'b0; fmt = f;
    repeat (4) @(negedge clk);
    got_n = 0; err_n = 0; max_run = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int f2 = 0; f2 < 8; f2++) begin
      tx_l[f2] = (32'h9E3779B9 * (f2 + 1)) ^ 32'h00C35A71;
      tx_r[f2] = (32'h7F4A7C15 * (f2 + 3)) ^ 32'h0051E6A9;
    end
  endtask

  task automatic slot(input logic w, input logic d);
    bck = 1'b0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one bit-clock delay on data, as I2S needs
  task automatic dslot(input logic w, input logic nxt);
    slot(w, dly);
    dly = nxt;
  endtask

  function automatic logic [23:0] exp_i2s(input logic [31:0] w, input int wlen);
    logic [31:0] m;
    m = (wlen >= 32) ? w : (w & ((32'd1 << wlen) - 1));
    if (wlen >= 24) return 24'(m >> (wlen - 24));
    else            return 24'(m << (24 - wlen));
  endfunction

  task automatic send_i2s(input int n, input int wlen, input int half);
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < half; k++) dslot(1'b0, (k < wlen) ? tx_l[f][wlen-1-k] : 1'b0);
      for (int k = 0; k < half; k++) dslot(1'b1, (k < wlen) ? tx_r[f][wlen-1-k] : 1'b0);
    end
    dslot(1'b0, 1'b0);
    dslot(1'b0, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic send_rj(input int n, input int hi, input int lo);
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < hi; k++) slot(1'b1, (k >= hi - 16) ? tx_l[f][hi-1-k] : 1'b0);
      for (int k = 0; k < lo; k++) slot(1'b0, (k >= lo - 16) ? tx_r[f][lo-1-k] : 1'b0);
    end
    slot(1'b1, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic send_dsp(input int n, input int sync, input int total, input logic early);
    for (int f = 0; f < n; f++) begin
      logic [31:0] pair;
      pair = {tx_l[f][15:0], tx_r[f][15:0]};
      for (int k = 0; k < total; k++) begin
        int idx;
        idx = k - (early ? 0 : sync);
        slot(k < sync, (idx >= 0 && idx < 32) ? pair[31-idx] : 1'b0);
      end
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frames(input string tag, input int n, input bit wide, input int wlen);
    chk({tag, " frame count (first frame dropped, R10)"}, got_n, n - 1);
    chk({tag, " strobe width R8"}, max_run, 1);
    for (int f = 1; f < n; f++) begin
      logic [23:0] el, er;
      el = wide ? exp_i2s(tx_l[f], wlen) : {tx_l[f][15:0], 8'h00};
      er = wide ? exp_i2s(tx_r[f], wlen) : {tx_r[f][15:0], 8'h00};
      chk({tag, " left"},  {8'h0, got_l[f-1]}, {8'h0, el});
      chk({tag, " right"}, {8'h0, got_r[f-1]}, {8'h0, er});
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 mode in reset", mode, 0);
    chk("R1 left in reset", left, 0);
    do_reset(1'b1);
    repeat (20) @(negedge clk);
    chk("R1 err after reset", err, 0);
    chk("R1 right after reset", right, 0);
    chk("R1 mode after reset", mode, 0);
  endtask

  task automatic t_i2s24;
    do_reset(1'b1);
    send_i2s(4, 24, 32);
    chk("R2 mode i2s", mode, 2);
    check_frames("R2 i2s 24b", 4, 1'b1, 24);
    chk("R9 no error i2s", err_n, 0);
  endtask

  task automatic t_i2s_pad;
    do_reset(1'b1);
    send_i2s(3, 20, 24);
    check_frames("R3 i2s 20b padded", 3, 1'b1, 20);
  endtask

  task automatic t_i2s_trunc;
    do_reset(1'b1);
    send_i2s(3, 32, 32);
    check_frames("R3 i2s 32b truncated", 3, 1'b1, 32);
  endtask

  task automatic t_rj;
    do_reset(1'b0);
    send_rj(4, 24, 20);
    chk("R4 mode rj", mode, 1);
    check_frames("R4 rj16", 4, 1'b0, 16);
  endtask

  task automatic t_pack;
    do_reset(1'b1);
    send_i2s(3, 16, 16);
    chk("R5 mode packed fmt1", mode, 3);
    check_frames("R5 packed fmt1", 3, 1'b1, 16);
    do_reset(1'b0);
    send_rj(3, 16, 16);
    chk("R5 mode packed fmt0", mode, 3);
    check_frames("R5 packed fmt0", 3, 1'b0, 16);
  endtask

  task automatic t_dsp_late;
    do_reset(1'b0);
    send_dsp(3, 2, 40, 1'b0);
    chk("R6 mode dsp late", mode, 4);
    check_frames("R7 dsp late", 3, 1'b0, 16);
  endtask

  task automatic t_dsp_early;
    do_reset(1'b1);
    send_dsp(3, 4, 36, 1'b1);
    chk("R6 mode dsp early sync4", mode, 5);
    check_frames("R7 dsp early", 3, 1'b0, 16);
  endtask

  task automatic t_sync5;
    do_reset(1'b0);
    send_rj(3, 5, 35);
    chk("R6 sync5 not dsp", mode, 1);
    chk("R9 sync5 short half errors", err_n, 2);
    chk("R9 sync5 no sample", got_n, 0);
  endtask

  task automatic t_short;
    do_reset(1'b1);
    send_i2s(3, 12, 12);
    chk("R9 short halves errors", err_n, 2);
    chk("R9 short halves no sample", got_n, 0);
    chk("R10 mode still i2s", mode, 2);
  endtask

  initial begin
    t_reset();
    t_i2s24();
    t_i2s_pad();
    t_i2s_trunc();
    t_rj();
    t_pack();
    t_dsp_late();
    t_dsp_early();
    t_sync5();
    t_short();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule